// File: doc/BRIEF.md
# GPIB Control-Line Fast Responder

This block sits between a slow interface microcontroller and the control lines of a GPIB bus. It samples the low-true REN, IFC and ATN lines through a synchronizer and reacts to ATN and IFC in hardware. When either line is asserted, it turns the data-line and handshake-line transceivers to receive, and it does not wait for the firmware to do so. It also records REN and IFC events in sticky flags, which the firmware reads and then clears through a narrow register port.

The firmware asks for transmit direction on the data lines and on the handshake lines through the same write word. The block honours the request only while the bus controller holds neither ATN nor IFC. While IFC is asserted, both transceivers are also chip-disabled and a halt indication is raised. The service-request output follows a single firmware bit. A per-flag watchdog reports a flag that the firmware has left set longer than its allowed window, which is one millisecond at the default setting.

Top module: `gpib_line_responder`

## Requirements
- R1: Bus lines are low-true. Read word bit 2 shows ATN asserted, bit 3 shows REN asserted and bit 4 shows IFC asserted; each reads 1 when its line is low.
- R2: A bus-line change reaches the live read bits and the transceiver controls at the second rising clock edge after the change, and not at the first.
- R3: Read bit 0 (REN flag) becomes 1 one edge after REN reaches the live bits. It stays 1 after REN is released, until the firmware clears it.
- R4: Read bit 1 (IFC flag) becomes 1 one edge after IFC reaches the live bits. It stays 1 after IFC is released, until the firmware clears it.
- R5: A register write with write bit 0 set clears the REN flag, and one with write bit 1 set clears the IFC flag. A write with the clear bit at 0 leaves that flag unchanged.
- R6: If a clear is written while its line is still asserted, the set wins and the flag stays 1.
- R7: While ATN is asserted, data_te and hs_te are 0 (receive) and data_cd and hs_cd stay 0.
- R8: While IFC is asserted, data_te and hs_te are 0, data_cd and hs_cd are 1, and bus_halted is 1.
- R9: Write bit 2 requests data transmit and write bit 3 requests handshake transmit. Every write replaces both requests. A request drives data_te or hs_te only while neither ATN nor IFC is asserted, and it takes effect again once both are released.
- R10: latch_stale[0] (REN) or latch_stale[1] (IFC) becomes 1 at the TIMEOUT_CYCLES-th edge after its flag was set, provided the flag is still uncleared. It returns to 0 as soon as the flag is cleared.
- R11: Write bit 4 is the service request. srq_n is 0 exactly when the last written value of that bit is 1.
- R12: After reset, the read word is 0, both te and both cd outputs are 0, bus_halted is 0, srq_n is 1 and latch_stale is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_ren_n | input | 1 | REN bus line, low-true |
| bus_ifc_n | input | 1 | IFC bus line, low-true |
| bus_atn_n | input | 1 | ATN bus line, low-true |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 5 | Write word: clears, transmit requests, service request |
| reg_rdata | output | 5 | Read word: sticky flags and live line levels |
| data_te | output | 1 | Data transceiver direction, 1 = transmit |
| data_cd | output | 1 | Data transceiver chip disable |
| hs_te | output | 1 | Handshake transceiver direction, 1 = transmit |
| hs_cd | output | 1 | Handshake transceiver chip disable |
| bus_halted | output | 1 | IFC halt indication |
| srq_n | output | 1 | Service request line, low-true |
| latch_stale | output | 2 | Flag left set too long, [0] REN, [1] IFC |

## Verification
A line change reaches the live bits and the transceiver controls two edges after it is applied, and the sticky flags follow one edge later. A register write takes effect at the edge that samples it. The stale indication rises exactly TIMEOUT_CYCLES edges after its flag was set. The bench changes inputs on falling edges and samples on falling edges, so each check falls between the edges in question. For the line path, the bench checks one edge early that nothing has moved yet, and then checks the value at the edge where it is due.

// File: rtl/gcr_pkg.sv
// Package: shared field positions and widths for the GPIB control-line responder.
// Assumes the register port is a plain single-cycle write strobe and a
// combinational read word.
package gcr_pkg;
    localparam int WR_W        = 5;
    localparam int RD_W        = 5;
    localparam int NUM_LINES   = 3;
    localparam int NUM_FLAGS   = 2;

    // Index of each synchronized line inside the line vector
    localparam int LN_REN      = 0;
    localparam int LN_IFC      = 1;
    localparam int LN_ATN      = 2;

    // Write word fields
    localparam int WB_CLR_REN  = 0;
    localparam int WB_CLR_IFC  = 1;
    localparam int WB_TX_DATA  = 2;
    localparam int WB_TX_HS    = 3;
    localparam int WB_SRQ      = 4;

    // Read word fields
    localparam int RB_FLAG_REN = 0;
    localparam int RB_FLAG_IFC = 1;
    localparam int RB_LIVE_ATN = 2;
    localparam int RB_LIVE_REN = 3;
    localparam int RB_LIVE_IFC = 4;

    typedef struct packed {
        logic te;   // 1 = transmit, 0 = receive
        logic cd;   // 1 = chip disabled
    } xcvr_ctl_t;
endpackage

// File: rtl/gcr_sync.sv
// Module: gcr_sync
// Multi-bit synchronizer built as a chain of flops for asynchronous, active-high
// levels. Assumes each bit is independent, so no coherency between bits is needed.
// Reset clears every stage to 0, which means deasserted.
module gcr_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);
    logic [W-1:0] stg [STAGES];

    // Shift the sampled levels through the chain of stages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d_in;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q_out = stg[STAGES-1];
endmodule

// File: rtl/gcr_evt_latch.sv
// Module: gcr_evt_latch
// Sticky event flag with a watchdog on how long it stays set. The flag sets on
// an asserted, already-synchronized level. The set has priority over a clear
// in the same cycle. stale rises when the flag has been held LIMIT edges.
module gcr_evt_latch #(
    parameter int LIMIT = 200_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_lvl,
    input  logic clr,
    output logic held,
    output logic stale
);
    localparam int CW = $clog2(LIMIT + 1);

    logic          flag_q;
    logic [CW-1:0] age_q;

    // Sticky flag: the set wins over the clear
    always_ff @(posedge clk) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (set_lvl) flag_q <= 1'b1;
        else if (clr)     flag_q <= 1'b0;
    end

    // Age counter: runs while the flag is set and saturates at LIMIT
    always_ff @(posedge clk) begin
        if (!rst_n || !flag_q)        age_q <= '0;
        else if (age_q != CW'(LIMIT)) age_q <= age_q + 1'b1;
    end

    assign held  = flag_q;
    assign stale = flag_q && (age_q == CW'(LIMIT));
endmodule

// File: rtl/gcr_xcvr_ctl.sv
// Module: gcr_xcvr_ctl
// Combinational override of the transceiver controls. ATN or IFC forces receive.
// IFC also disables both chips and raises the halt indication. Assumes atn and
// ifc are synchronized and active high.
module gcr_xcvr_ctl
    import gcr_pkg::*;
(
    input  logic      atn,
    input  logic      ifc,
    input  logic      req_data,
    input  logic      req_hs,
    output xcvr_ctl_t data_ctl,
    output xcvr_ctl_t hs_ctl,
    output logic      halted
);
    logic block_tx;

    // Decide direction and enable from the bus state and the firmware request
    always_comb begin
        block_tx    = atn || ifc;
        data_ctl.te = req_data && !block_tx;
        hs_ctl.te   = req_hs   && !block_tx;
        data_ctl.cd = ifc;
        hs_ctl.cd   = ifc;
        halted      = ifc;
    end
endmodule

// File: rtl/gpib_line_responder.sv
// Module: gpib_line_responder (top)
// Fast hardware responder for the GPIB REN, IFC and ATN control lines. It
// synchronizes the low-true lines, keeps sticky REN and IFC flags with stale
// watchdogs, overrides transceiver direction in hardware, and holds the
// firmware transmit requests and the service-request bit.
// Assumes: the bus lines are asynchronous to clk; TIMEOUT_CYCLES equals 1 ms
// of clk (200 MHz by default).
module gpib_line_responder
    import gcr_pkg::*;
#(
    parameter int SYNC_STAGES    = 2,
    parameter int TIMEOUT_CYCLES = 200_000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_ren_n,
    input  logic            bus_ifc_n,
    input  logic            bus_atn_n,
    input  logic            reg_wr_en,
    input  logic [WR_W-1:0] reg_wdata,
    output logic [RD_W-1:0] reg_rdata,
    output logic            data_te,
    output logic            data_cd,
    output logic            hs_te,
    output logic            hs_cd,
    output logic            bus_halted,
    output logic            srq_n
    ,
    output logic [NUM_FLAGS-1:0] latch_stale
);
    logic [NUM_LINES-1:0] line_raw;
    logic [NUM_LINES-1:0] line_s;
    logic [NUM_FLAGS-1:0] flag_set;
    logic [NUM_FLAGS-1:0] flag_clr;
    logic [NUM_FLAGS-1:0] flag_held;
    logic                 req_data_q;
    logic                 req_hs_q;
    logic                 srq_q;
    xcvr_ctl_t            data_ctl;
    xcvr_ctl_t            hs_ctl;

    // Turn the low-true pins into active-high levels
    always_comb begin
        line_raw[LN_REN] = !bus_ren_n;
        line_raw[LN_IFC] = !bus_ifc_n;
        line_raw[LN_ATN] = !bus_atn_n;
    end

    gcr_sync #(.W(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (line_raw),
        .q_out (line_s)
    );

    // Map the set and clear sources onto the flag slots (0 = REN, 1 = IFC)
    always_comb begin
        flag_set[0] = line_s[LN_REN];
        flag_set[1] = line_s[LN_IFC];
        flag_clr[0] = reg_wr_en && reg_wdata[WB_CLR_REN];
        flag_clr[1] = reg_wr_en && reg_wdata[WB_CLR_IFC];
    end

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        gcr_evt_latch #(.LIMIT(TIMEOUT_CYCLES)) u_latch (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_lvl (flag_set[g]),
            .clr     (flag_clr[g]),
            .held    (flag_held[g]),
            .stale   (latch_stale[g])
        );
    end

    // Firmware control bits: every write replaces them
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_data_q <= 1'b0;
            req_hs_q   <= 1'b0;
            srq_q      <= 1'b0;
        end else if (reg_wr_en) begin
            req_data_q <= reg_wdata[WB_TX_DATA];
            req_hs_q   <= reg_wdata[WB_TX_HS];
            srq_q      <= reg_wdata[WB_SRQ];
        end
    end

    gcr_xcvr_ctl u_xcvr (
        .atn      (line_s[LN_ATN]),
        .ifc      (line_s[LN_IFC]),
        .req_data (req_data_q),
        .req_hs   (req_hs_q),
        .data_ctl (data_ctl),
        .hs_ctl   (hs_ctl),
        .halted   (bus_halted)
    );

    // Assemble the read word and drive the pins
    always_comb begin
        reg_rdata              = '0;
        reg_rdata[RB_FLAG_REN] = flag_held[0];
        reg_rdata[RB_FLAG_IFC] = flag_held[1];
        reg_rdata[RB_LIVE_ATN] = line_s[LN_ATN];
        reg_rdata[RB_LIVE_REN] = line_s[LN_REN];
        reg_rdata[RB_LIVE_IFC] = line_s[LN_IFC];
        data_te                = data_ctl.te;
        data_cd                = data_ctl.cd;
        hs_te                  = hs_ctl.te;
        hs_cd                  = hs_ctl.cd;
        srq_n                  = !srq_q;
    end
endmodule

// File: rtl/gcr_chk.sv
// Module: gcr_chk
// Property checker attached to gpib_line_responder with a bind statement. It
// looks only at the ports of the top module.
module gcr_chk
    import gcr_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_wr_en,
    input logic [WR_W-1:0]      reg_wdata,
    input logic [RD_W-1:0]      reg_rdata,
    input logic                 data_te,
    input logic                 data_cd,
    input logic                 hs_te,
    input logic                 hs_cd,
    input logic                 bus_halted,
    input logic                 srq_n,
    input logic [NUM_FLAGS-1:0] latch_stale
);
    // R7
    atn_forces_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[RB_LIVE_ATN] |-> (!data_te && !hs_te));

    // R8
    ifc_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[RB_LIVE_IFC] |-> (!data_te && !hs_te && data_cd && hs_cd && bus_halted));

    // R3
    ren_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[RB_FLAG_REN] && !(reg_wr_en && reg_wdata[WB_CLR_REN])) |=> reg_rdata[RB_FLAG_REN]);

    // R4
    ifc_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[RB_FLAG_IFC] && !(reg_wr_en && reg_wdata[WB_CLR_IFC])) |=> reg_rdata[RB_FLAG_IFC]);

    // R10
    stale_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch_stale[0] || reg_rdata[RB_FLAG_REN]) && (!latch_stale[1] || reg_rdata[RB_FLAG_IFC]));

    // R11
    srq_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> (srq_n == !$past(reg_wdata[WB_SRQ])));

    // R9
    tx_needs_quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_te || hs_te) |-> (!reg_rdata[RB_LIVE_ATN] && !reg_rdata[RB_LIVE_IFC]));
endmodule

bind gpib_line_responder gcr_chk u_chk (.*);

// File: tb/gpib_line_responder_bench.sv
// Directed bench for gpib_line_responder. Each scenario task checks its own results.
module gpib_line_responder_bench;
    localparam int LIMIT = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_ren_n = 1'b1;
    logic       bus_ifc_n = 1'b1;
    logic       bus_atn_n = 1'b1;
    logic       reg_wr_en = 1'b0;
    logic [4:0] reg_wdata = '0;
    logic [4:0] reg_rdata;
    logic       data_te, data_cd, hs_te, hs_cd, bus_halted, srq_n;
    logic [1:0] latch_stale;

    int n_checks = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    gpib_line_responder #(.TIMEOUT_CYCLES(LIMIT)) u_gpib_line_responder (
        .clk(clk), .rst_n(rst_n),
        .bus_ren_n(bus_ren_n), .bus_ifc_n(bus_ifc_n), .bus_atn_n(bus_atn_n),
        .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .data_te(data_te), .data_cd(data_cd), .hs_te(hs_te), .hs_cd(hs_cd),
        .bus_halted(bus_halted), .srq_n(srq_n), .latch_stale(latch_stale)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Advance n rising edges and stop on the following falling edge
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // One register write sampled at the next rising edge
    task automatic wr(input logic [4:0] w);
        reg_wr_en = 1'b1;
        reg_wdata = w;
        step(1);
        reg_wr_en = 1'b0;
        reg_wdata = '0;
    endtask

    // {data_te, data_cd, hs_te, hs_cd, bus_halted}
    function automatic logic [4:0] ctl();
        return {data_te, data_cd, hs_te, hs_cd, bus_halted};
    endfunction

    task automatic t_reset();
        chk("R12 rdata", reg_rdata, 5'h00);
        chk("R12 ctl", ctl(), 5'b00000);
        chk("R12 srq_n", srq_n, 1'b1);
        chk("R12 stale", latch_stale, 2'b00);
    endtask

    task automatic t_ren_latch();
        bus_ren_n = 1'b0;
        step(1);
        chk("R2 ren not yet live", reg_rdata, 5'h00);
        step(1);
        chk("R1 ren live bit3", reg_rdata, 5'b01000);
        step(1);
        chk("R3 ren flag set", reg_rdata, 5'b01001);
        bus_ren_n = 1'b1;
        step(5);
        chk("R3 ren flag sticky", reg_rdata, 5'b00001);
        wr(5'b00001);
        chk("R5 ren cleared", reg_rdata, 5'b00000);
    endtask

    task automatic t_ifc_halt();
        wr(5'b01100);
        chk("R9 tx both", ctl(), 5'b10100);
        bus_ifc_n = 1'b0;
        step(1);
        chk("R2 ifc not yet acted", ctl(), 5'b10100);
        step(1);
        chk("R8 ifc release", ctl(), 5'b01011);
        chk("R1 ifc live bit4", reg_rdata, 5'b10000);
        step(1);
        chk("R4 ifc flag set", reg_rdata, 5'b10010);
        bus_ifc_n = 1'b1;
        step(2);
        chk("R9 tx back after ifc", ctl(), 5'b10100);
        chk("R4 ifc flag sticky", reg_rdata, 5'b00010);
        wr(5'b00010);
        chk("R5 ifc cleared", reg_rdata, 5'b00000);
        chk("R9 write replaces requests", ctl(), 5'b00000);
    endtask

    task automatic t_atn_override();
        wr(5'b00100);
        chk("R9 data tx only", ctl(), 5'b10000);
        bus_atn_n = 1'b0;
        step(1);
        chk("R2 atn not yet acted", ctl(), 5'b10000);
        step(1);
        chk("R7 atn forces rx", ctl(), 5'b00000);
        chk("R1 atn live bit2", reg_rdata, 5'b00100);
        wr(5'b01100);
        chk("R9 request ignored under atn", ctl(), 5'b00000);
        bus_atn_n = 1'b1;
        step(2);
        chk("R9 request honoured after atn", ctl(), 5'b10100);
        chk("R7 no flag from atn", reg_rdata, 5'b00000);
        wr(5'b00000);
    endtask

    task automatic t_clear_rules();
        bus_ren_n = 1'b0;
        bus_ifc_n = 1'b0;
        step(3);
        chk("R3 R4 both flags", reg_rdata[1:0], 2'b11);
        wr(5'b00011);
        chk("R6 set beats clear", reg_rdata[1:0], 2'b11);
        bus_ren_n = 1'b1;
        bus_ifc_n = 1'b1;
        step(2);
        wr(5'b00000);
        chk("R5 zero write keeps flags", reg_rdata[1:0], 2'b11);
        wr(5'b00001);
        chk("R5 clear ren only", reg_rdata[1:0], 2'b10);
        wr(5'b00010);
        chk("R5 clear ifc", reg_rdata[1:0], 2'b00);
    endtask

    task automatic t_watchdog();
        bus_ifc_n = 1'b0;
        step(3);
        bus_ifc_n = 1'b1;
        chk("R10 fresh flag", latch_stale, 2'b00);
        step(LIMIT - 1);
        chk("R10 one edge early", latch_stale, 2'b00);
        step(1);
        chk("R10 stale at limit", latch_stale, 2'b10);
        wr(5'b00010);
        chk("R10 stale cleared", latch_stale, 2'b00);
    endtask

    task automatic t_srq();
        wr(5'b10000);
        chk("R11 srq asserted", srq_n, 1'b0);
        wr(5'b00000);
        chk("R11 srq released", srq_n, 1'b1);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_ren_latch();
        t_ifc_halt();
        t_atn_override();
        t_clear_rules();
        t_watchdog();
        t_srq();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule